// File: doc/BRIEF.md
# I2C Page-Write EEPROM Slave

This block is the bus-facing write side of a small serial memory. It watches a two-wire I2C bus (clock and data, the data line open-drain), recognises START and STOP, and answers only to a first byte whose top nibble is the device-type code 1010. A write request is then followed by one byte that selects any of the 256 byte locations, and by one or more data bytes. The block acknowledges each of these bytes by pulling the data line low during the ninth clock.

Data bytes are not written to the array as they arrive. They are collected into a page buffer that covers one 16-byte page. The buffer address advances only in its low four bits, so a long burst wraps back to the start of the same page and overwrites what it sent earlier. The array is updated only when STOP ends a write that carried at least one data byte. The commit then runs as a timed write cycle of a parameterised length. While that cycle runs the block reports busy and takes no notice of the bus. A plain read port on the array lets the surrounding read logic see the stored bytes.

Top module: `i2c_page_writer`

## Requirements
- R1: After reset the data-line pull-down is released, busy is low, and every array location reads the erase value 8'hFF.
- R2: The block acknowledges a first byte after START only when bits 7:4 equal 4'b1010. Bits 3:1 of that byte are ignored. For any other top nibble the data line stays released for the rest of the transfer.
- R3: Bit 0 of the first byte selects the direction, 0 for write and 1 for read. A read request is acknowledged, but after it no byte is acknowledged, no data is stored and no write cycle starts.
- R4: During a write, the data line is pulled low while SCL is high in the ninth clock after the device byte, after the word-address byte, and after every data byte.
- R5: The n-th data byte of a write (n counted from 0) goes to the address whose bits 7:4 equal those of the word address and whose bits 3:0 equal the low nibble of the word address plus n, modulo 16.
- R6: When more than 16 data bytes arrive before STOP, a later byte that lands on the same location replaces the earlier one, and the array holds the last byte sent for that location.
- R7: No array location changes before STOP. Busy rises within a few clocks after a STOP that ends a write carrying data.
- R8: Busy stays high for exactly WR_CYCLES clocks. While busy is high, bus activity gets no acknowledge and has no effect on the array.
- R9: Only the locations that received data in the transaction are changed. Every other byte, including the rest of the same page, keeps its value.
- R10: No write cycle starts when STOP or START arrives after two or more SCL pulses of an unfinished data byte, or when STOP follows a write that carried no data byte. A STOP is counted as ending the write cleanly when it comes at most one SCL pulse (its own) after the last acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as sensed |
| sda_i | input | 1 | Bus data line as sensed (wired level) |
| sda_oe | output | 1 | Pulls the data line low when high |
| busy | output | 1 | High while the timed write cycle runs |
| rd_addr | input | ADDR_W | Array read address |
| rd_data | output | 8 | Array byte at rd_addr, combinational |

## Verification
A wrong bit counter or a wrong link state shows at the ports within one byte time. The acknowledge pulse then appears on the wrong clock or goes missing, and the bench samples sda_oe during every ninth SCL high. A wrong page pointer or a wrong valid mask stays hidden until the commit ends. After every commit the whole array is read back and compared with a model of the wrapped page, so a misplaced or stray byte shows within WR_CYCLES clocks after STOP. A fault in the abort or busy logic shows as a busy pulse that should not occur, or one of the wrong length.

// File: rtl/i2cw_pkg.sv
package i2cw_pkg;

    typedef logic [7:0] byte_t;

    localparam logic [3:0] DEV_TYPE  = 4'b1010;
    localparam int         BIT_CNT_W = 4;
    localparam logic [BIT_CNT_W-1:0] BITS_PER_BYTE = 4'd8;

    typedef enum logic [2:0] {
        LS_IDLE,
        LS_DEV,
        LS_DEV_ACK,
        LS_WADDR,
        LS_WADDR_ACK,
        LS_DATA,
        LS_DATA_ACK,
        LS_HOLD
    } link_state_t;

    typedef struct packed {
        logic scl_s;
        logic sda_s;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } bus_ev_t;

    function automatic logic dev_match(byte_t b);
        return b[7:4] == DEV_TYPE;
    endfunction

    function automatic logic is_rx_state(link_state_t s);
        return (s == LS_DEV) || (s == LS_WADDR) || (s == LS_DATA);
    endfunction

endpackage

// File: rtl/i2cw_sync.sv
module i2cw_sync
    import i2cw_pkg::*;
#(
    parameter int SYNC_N = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_i,
    input  logic    sda_i,
    output bus_ev_t ev
);
    localparam int LINES = 2;   // index 1 = clock line, 0 = data line

    logic [LINES-1:0] raw;
    logic [LINES-1:0] synced;
    logic [LINES-1:0] prev;

    assign raw = {scl_i, sda_i};

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [SYNC_N-1:0] chain;
        always_ff @(posedge clk) begin
            if (rst) chain <= '1;
            else     chain <= {chain[SYNC_N-2:0], raw[g]};
        end
        assign synced[g] = chain[SYNC_N-1];
    end

    always_ff @(posedge clk) begin
        if (rst) prev <= '1;
        else     prev <= synced;
    end

    always_comb begin
        ev.scl_s    = synced[1];
        ev.sda_s    = synced[0];
        ev.scl_rise = synced[1] & ~prev[1];
        ev.scl_fall = ~synced[1] & prev[1];
        ev.start    = synced[1] & prev[1] & prev[0] & ~synced[0];
        ev.stop     = synced[1] & prev[1] & ~prev[0] & synced[0];
    end

endmodule

// File: rtl/i2cw_link.sv
module i2cw_link
    import i2cw_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  bus_ev_t ev,
    input  logic    busy,
    input  logic    have_data,
    output logic    sda_oe,
    output byte_t   rx_byte,
    output logic    addr_ld,
    output logic    data_stb,
    output logic    clr,
    output logic    commit
);
    link_state_t          state;
    logic [BIT_CNT_W-1:0] bit_cnt;
    logic                 rw_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= LS_IDLE;
            bit_cnt  <= '0;
            rw_q     <= 1'b0;
            rx_byte  <= '0;
            sda_oe   <= 1'b0;
            addr_ld  <= 1'b0;
            data_stb <= 1'b0;
            clr      <= 1'b0;
            commit   <= 1'b0;
        end else begin
            addr_ld  <= 1'b0;
            data_stb <= 1'b0;
            clr      <= 1'b0;
            commit   <= 1'b0;
            if (busy) begin
                state   <= LS_IDLE;
                bit_cnt <= '0;
                sda_oe  <= 1'b0;
            end else if (ev.start) begin
                state   <= LS_DEV;
                bit_cnt <= '0;
                sda_oe  <= 1'b0;
                clr     <= 1'b1;
            end else if (ev.stop) begin
                // only the STOP's own SCL pulse may follow the last ACK
                if (state == LS_DATA && bit_cnt <= 1 && have_data)
                    commit <= 1'b1;
                state   <= LS_IDLE;
                bit_cnt <= '0;
                sda_oe  <= 1'b0;
            end else if (is_rx_state(state)) begin
                if (ev.scl_rise && bit_cnt < BITS_PER_BYTE) begin
                    rx_byte <= {rx_byte[6:0], ev.sda_s};
                    bit_cnt <= bit_cnt + 1'b1;
                end else if (ev.scl_fall && bit_cnt == BITS_PER_BYTE) begin
                    bit_cnt <= '0;
                    unique case (state)
                        LS_DEV: begin
                            if (dev_match(rx_byte)) begin
                                rw_q   <= rx_byte[0];
                                sda_oe <= 1'b1;
                                state  <= LS_DEV_ACK;
                            end else begin
                                state  <= LS_HOLD;
                            end
                        end
                        LS_WADDR: begin
                            addr_ld <= 1'b1;
                            sda_oe  <= 1'b1;
                            state   <= LS_WADDR_ACK;
                        end
                        default: begin
                            data_stb <= 1'b1;
                            sda_oe   <= 1'b1;
                            state    <= LS_DATA_ACK;
                        end
                    endcase
                end
            end else if (ev.scl_fall) begin
                bit_cnt <= '0;
                sda_oe  <= 1'b0;
                case (state)
                    LS_DEV_ACK:   state <= rw_q ? LS_HOLD : LS_WADDR;
                    LS_WADDR_ACK: state <= LS_DATA;
                    LS_DATA_ACK:  state <= LS_DATA;
                    default:      state <= state;
                endcase
            end
        end
    end

    p_no_ack_busy_r8: assert property (@(posedge clk) disable iff (rst)
        busy |-> !sda_oe);

    p_ack_scl_low_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_oe) |-> !ev.scl_s);

    p_commit_data_r10: assert property (@(posedge clk) disable iff (rst)
        commit |-> have_data);

endmodule

// File: rtl/i2cw_page.sv
module i2cw_page
    import i2cw_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int PAGE_W = 4
) (
    input  logic                           clk,
    input  logic                           rst,
    input  byte_t                          rx_byte,
    input  logic                           addr_ld,
    input  logic                           data_stb,
    input  logic                           clr,
    output logic [ADDR_W-PAGE_W-1:0]       page_q,
    output logic [(1<<PAGE_W)-1:0]         valid,
    output logic [(1<<PAGE_W)-1:0][7:0]    pg_data,
    output logic                           have_data
);
    localparam int PAGE_N = 1 << PAGE_W;

    logic [PAGE_W-1:0] ptr;

    always_ff @(posedge clk) begin
        if (rst) begin
            page_q  <= '0;
            ptr     <= '0;
            valid   <= '0;
            pg_data <= '0;
        end else if (clr) begin
            valid <= '0;
        end else if (addr_ld) begin
            page_q <= rx_byte[ADDR_W-1:PAGE_W];
            ptr    <= rx_byte[PAGE_W-1:0];
            valid  <= '0;
        end else if (data_stb) begin
            pg_data[ptr] <= rx_byte;
            valid[ptr]   <= 1'b1;
            ptr          <= ptr + 1'b1;   // wraps inside the page
        end
    end

    assign have_data = |valid;

    p_page_hold_r5: assert property (@(posedge clk) disable iff (rst)
        data_stb |=> $stable(page_q));

endmodule

// File: rtl/i2cw_store.sv
module i2cw_store
    import i2cw_pkg::*;
#(
    parameter int    ADDR_W    = 8,
    parameter int    PAGE_W    = 4,
    parameter int    WR_CYCLES = 64,
    parameter byte_t ERASE_VAL = 8'hFF
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           commit,
    input  logic [ADDR_W-PAGE_W-1:0]       page_q,
    input  logic [(1<<PAGE_W)-1:0]         valid,
    input  logic [(1<<PAGE_W)-1:0][7:0]    pg_data,
    input  logic [ADDR_W-1:0]              rd_addr,
    output byte_t                          rd_data,
    output logic                           busy
);
    localparam int DEPTH  = 1 << ADDR_W;
    localparam int PAGE_N = 1 << PAGE_W;
    localparam int CYC    = (WR_CYCLES > PAGE_N) ? WR_CYCLES : PAGE_N;
    localparam int CNT_W  = $clog2(CYC + 1);

    byte_t             mem [DEPTH];
    logic [CNT_W-1:0]  elapsed;
    logic [PAGE_W-1:0] widx;
    logic              mem_we;

    assign widx   = elapsed[PAGE_W-1:0];
    assign mem_we = busy && (elapsed < CNT_W'(PAGE_N)) && valid[widx];

    always_ff @(posedge clk) begin
        if (rst) begin
            busy    <= 1'b0;
            elapsed <= '0;
        end else if (busy) begin
            if (elapsed == CNT_W'(CYC - 1)) begin
                busy    <= 1'b0;
                elapsed <= '0;
            end else begin
                elapsed <= elapsed + 1'b1;
            end
        end else if (commit) begin
            busy    <= 1'b1;
            elapsed <= '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= ERASE_VAL;
        end else if (mem_we) begin
            mem[{page_q, widx}] <= pg_data[widx];
        end
    end

    assign rd_data = mem[rd_addr];

    p_busy_after_commit_r7: assert property (@(posedge clk) disable iff (rst)
        commit |=> busy);

    p_buf_frozen_r9: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> ($stable(valid) && $stable(page_q)));

endmodule

// File: rtl/i2c_page_writer.sv
module i2c_page_writer
    import i2cw_pkg::*;
#(
    parameter int          ADDR_W    = 8,
    parameter int          PAGE_W    = 4,
    parameter int          WR_CYCLES = 64,
    parameter int          SYNC_N    = 2,
    parameter logic [7:0]  ERASE_VAL = 8'hFF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    output logic              busy,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data
);
    localparam int PAGE_N = 1 << PAGE_W;
    localparam int HI_W   = ADDR_W - PAGE_W;

    bus_ev_t                  ev;
    byte_t                    rx_byte;
    logic                     addr_ld, data_stb, clr, commit, have_data;
    logic [HI_W-1:0]          page_q;
    logic [PAGE_N-1:0]        valid;
    logic [PAGE_N-1:0][7:0]   pg_data;

    i2cw_sync #(.SYNC_N(SYNC_N)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev    (ev)
    );

    i2cw_link u_link (
        .clk       (clk),
        .rst       (rst),
        .ev        (ev),
        .busy      (busy),
        .have_data (have_data),
        .sda_oe    (sda_oe),
        .rx_byte   (rx_byte),
        .addr_ld   (addr_ld),
        .data_stb  (data_stb),
        .clr       (clr),
        .commit    (commit)
    );

    i2cw_page #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_page (
        .clk       (clk),
        .rst       (rst),
        .rx_byte   (rx_byte),
        .addr_ld   (addr_ld),
        .data_stb  (data_stb),
        .clr       (clr),
        .page_q    (page_q),
        .valid     (valid),
        .pg_data   (pg_data),
        .have_data (have_data)
    );

    i2cw_store #(
        .ADDR_W    (ADDR_W),
        .PAGE_W    (PAGE_W),
        .WR_CYCLES (WR_CYCLES),
        .ERASE_VAL (ERASE_VAL)
    ) u_store (
        .clk     (clk),
        .rst     (rst),
        .commit  (commit),
        .page_q  (page_q),
        .valid   (valid),
        .pg_data (pg_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .busy    (busy)
    );

endmodule

// File: tb/i2c_page_writer_bench.sv
module i2c_page_writer_bench;
    localparam int WRC = 300;
    localparam int Q   = 6;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       m_scl = 1'b1;
    logic       m_sda = 1'b1;
    logic       sda_bus;
    logic       sda_oe, busy;
    logic [7:0] rd_addr = '0;
    logic [7:0] rd_data;

    logic [7:0] exp_mem [256];
    int checks = 0, fails = 0;
    int busy_len = 0, last_len = 0, busy_rises = 0;
    logic busy_d = 1'b0;
    bit done = 0;

    always #5 clk = ~clk;

    assign sda_bus = m_sda & ~sda_oe;

    i2c_page_writer #(.WR_CYCLES(WRC)) u_i2c_page_writer (
        .clk(clk), .rst(rst), .scl_i(m_scl), .sda_i(sda_bus),
        .sda_oe(sda_oe), .busy(busy), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    always @(negedge clk) begin
        if (busy) busy_len++;
        else if (busy_len != 0) begin last_len = busy_len; busy_len = 0; end
        if (busy && !busy_d) busy_rises++;
        busy_d = busy;
    end

    function automatic logic [7:0] exp_addr(logic [7:0] base, int n);
        logic [3:0] lo;
        lo = base[3:0] + n[3:0];
        return {base[7:4], lo};
    endfunction

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start;
        m_sda = 1'b1; tick(Q); m_scl = 1'b1; tick(Q);
        m_sda = 1'b0; tick(Q); m_scl = 1'b0; tick(Q);
    endtask

    task automatic bus_stop;
        m_sda = 1'b0; tick(Q); m_scl = 1'b1; tick(Q); m_sda = 1'b1; tick(Q);
    endtask

    task automatic send_bits(logic [7:0] b, int n);
        for (int i = 0; i < n; i++) begin
            m_sda = b[7-i]; tick(Q);
            m_scl = 1'b1;   tick(2*Q);
            m_scl = 1'b0;   tick(Q);
        end
    endtask

    task automatic send_byte(logic [7:0] b, output bit ack);
        send_bits(b, 8);
        m_sda = 1'b1; tick(Q);
        m_scl = 1'b1; tick(Q);
        ack = sda_oe;
        tick(Q);
        m_scl = 1'b0; tick(Q);
    endtask

    task automatic wait_idle;
        int n = 0;
        while (busy && n < 4*WRC) begin tick(1); n++; end
        tick(3);
    endtask

    task automatic mem_chk_all(string req);
        int bad = -1;
        logic [7:0] got = '0;
        for (int a = 0; a < 256; a++) begin
            rd_addr = a[7:0]; #1;
            if (bad < 0 && rd_data !== exp_mem[a]) begin bad = a; got = rd_data; end
        end
        checks++;
        if (bad >= 0) begin
            fails++;
            $display("FAIL %s: addr %0h actual %0h expected %0h", req, bad, got, exp_mem[bad]);
        end
    endtask

    // full write transaction with model update, ACK and busy-length checks
    task automatic write_txn(logic [7:0] dev, logic [7:0] addr, int n, string req);
        bit ack;
        int nacks = 0;
        logic [7:0] d;
        bus_start;
        send_byte(dev, ack);  if (!ack) nacks++;
        send_byte(addr, ack); if (!ack) nacks++;
        for (int i = 0; i < n; i++) begin
            d = 8'($urandom);
            send_byte(d, ack); if (!ack) nacks++;
            exp_mem[exp_addr(addr, i)] = d;
        end
        chk({req, " R4 missing acks"}, nacks, 0);
        bus_stop;
        wait_idle;
        chk("R8 busy length", last_len, WRC);
        mem_chk_all({req, " array"});
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        bit ack;
        int r0;
        void'($urandom(32'd1234));
        for (int a = 0; a < 256; a++) exp_mem[a] = 8'hFF;
        tick(4); rst = 1'b0; tick(4);

        // R1 reset state
        chk("R1 sda_oe", sda_oe, 0);
        chk("R1 busy", busy, 0);
        mem_chk_all("R1 erased");

        // R7 nothing lands before STOP
        bus_start;
        send_byte(8'hA0, ack); chk("R4 dev ack", ack, 1);
        send_byte(8'h37, ack); chk("R4 addr ack", ack, 1);
        send_byte(8'h5A, ack); chk("R4 data ack", ack, 1);
        rd_addr = 8'h37; #1;
        chk("R7 before stop", rd_data, 8'hFF);
        chk("R7 busy before stop", busy, 0);
        r0 = busy_rises;
        bus_stop;
        tick(2);
        chk("R7 busy after stop", busy_rises - r0, 1);
        wait_idle;
        exp_mem[8'h37] = 8'h5A;
        chk("R8 busy length", last_len, WRC);
        mem_chk_all("R7 single byte");

        // R5 full page wrap, R9 partial page, R6 overrun
        write_txn(8'hA0, 8'h5C, 16, "R5 page wrap");
        write_txn(8'hA0, 8'h93, 3, "R9 partial page");
        write_txn(8'hA0, 8'hA3, 21, "R6 overrun");

        // R2 device type and don't-care bits
        bus_start; send_byte(8'h90, ack); chk("R2 wrong type 9", ack, 0);
        send_byte(8'h11, ack); chk("R2 no ack later", ack, 0); bus_stop;
        bus_start; send_byte(8'hB0, ack); chk("R2 wrong type B", ack, 0); bus_stop;
        write_txn(8'hAE, 8'h02, 2, "R2 dont-care bits");

        // R3 read request
        r0 = busy_rises;
        bus_start; send_byte(8'hA1, ack); chk("R3 read acked", ack, 1);
        send_byte(8'h55, ack); chk("R3 no data ack", ack, 0);
        bus_stop; tick(20);
        chk("R3 no write cycle", busy_rises - r0, 0);

        // R8 deaf while busy
        bus_start; send_byte(8'hA0, ack); send_byte(8'h70, ack); send_byte(8'hC3, ack);
        bus_stop;
        exp_mem[8'h70] = 8'hC3;
        bus_start; send_byte(8'hA0, ack); chk("R8 no ack when busy", ack, 0);
        bus_stop;
        wait_idle;
        mem_chk_all("R8 deaf array");

        // R10 aborts and empty writes
        r0 = busy_rises;
        bus_start; send_byte(8'hA0, ack); send_byte(8'h20, ack); bus_stop; tick(20);
        chk("R10 stop without data", busy_rises - r0, 0);
        bus_start; send_byte(8'hA0, ack); send_byte(8'h30, ack);
        send_byte(8'h11, ack); send_byte(8'h22, ack); send_bits(8'h33, 4);
        bus_stop; tick(20);
        chk("R10 stop mid byte", busy_rises - r0, 0);
        mem_chk_all("R10 stop abort array");
        bus_start; send_byte(8'hA0, ack); send_byte(8'h40, ack);
        send_byte(8'h77, ack); send_bits(8'h0F, 3);
        bus_start; send_byte(8'hA0, ack); send_byte(8'h44, ack);
        send_byte(8'h99, ack); bus_stop;
        exp_mem[8'h44] = 8'h99;
        wait_idle;
        chk("R10 one commit after restart", busy_rises - r0, 1);
        mem_chk_all("R10 start abort array");

        // random transactions
        for (int t = 0; t < 10; t++) begin
            logic [7:0] a;
            int n;
            a = 8'($urandom);
            n = 1 + int'($urandom % 20);
            write_txn({4'b1010, 3'($urandom), 1'b0}, a, n, "R5 R6 R9 random");
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule